// File: doc/BRIEF.md
# Debug Trigger Chain Resolver

This block turns the raw match results of ten debug triggers into final fire decisions. The triggers come in five fixed pairs. Each trigger has an enable bit and a timing bit. Each pair has a chain bit that makes its two members fire only together. A hit vector arrives with a valid strobe. One registered stage later the block presents:

- the fire vector;
- a flag saying some fired trigger asks for a trap before the current instruction;
- a flag saying some fired trigger asks for a trap after it;
- a combined hit flag.

The configuration lives in local registers and is loaded through two small write ports. The fetch-side port reaches the four instruction-fetch triggers. The memory-side port reaches the six load and store triggers. Chaining the two store triggers of pair 1 is not allowed. The block reports that setting as a configuration error and treats the pair as unchained.

The pairs are numbered g = 0..4 and hold triggers 2g and 2g+1. Their kinds are:

| Pair | Triggers | Kinds |
|------|----------|-------|
| 0 | 0, 1 | fetch, fetch |
| 1 | 2, 3 | store, store |
| 2 | 4, 5 | load, load |
| 3 | 6, 7 | fetch, store |
| 4 | 8, 9 | fetch, load |

Top module: `trig_chain_resolver`

## Requirements
- R1: While reset is high and after it is released, all outputs are 0 and every trigger is disabled, unchained and has timing 0, so no hit vector fires anything until configuration is written.
- R2: `out_valid` is high exactly in the cycle after a cycle with `in_valid` high. After a cycle without `in_valid`, `fire`, `fire_now`, `fire_next` and `any_hit` are all 0.
- R3: A trigger in an unchained pair fires when it is enabled and its hit bit is set, whatever its partner does.
- R4: A disabled trigger never fires. In a chained pair it also prevents its partner from firing.
- R5: In a chained pair other than pair 1, the two triggers fire only when both are enabled and both hit, and then they both fire.
- R6: In a chained pair whose two timing bits differ, neither trigger fires, even when both hit.
- R7: `cfg_err` is 1 exactly while the chain bit of pair 1 (the two store triggers 2 and 3) is set. That chain bit has no effect on firing.
- R8: `fire_now` is 1 when some fired trigger has timing 0 (trap before the current instruction). `fire_next` is 1 when some fired trigger has timing 1 (trap after it).
- R9: `any_hit` is the OR of the fired fetch triggers (0, 1, 6, 8) and the fired load/store triggers (2, 3, 4, 5, 7, 9).
- R10: The configuration word layout is: bit 0 enable, bit 1 timing, bit 2 chain. The fetch port index maps 0,1,2,3 to triggers 0,1,6,8. The memory port index maps 0..5 to triggers 2,3,4,5,7,9, and indices 6 and 7 change nothing. Bit 2 sets a pair's chain only when the write targets the even trigger of the pair; it is ignored for odd triggers.
- R11: When a configuration write and a valid hit vector arrive in the same cycle, that evaluation uses the configuration as it stood before the write.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| cfg_fe_we | input | 1 | Fetch-side configuration write strobe |
| cfg_fe_idx | input | 2 | Fetch-side trigger index |
| cfg_fe_data | input | 3 | Fetch-side configuration word |
| cfg_me_we | input | 1 | Memory-side configuration write strobe |
| cfg_me_idx | input | 3 | Memory-side trigger index |
| cfg_me_data | input | 3 | Memory-side configuration word |
| in_valid | input | 1 | Hit vector valid |
| hit | input | 10 | Raw per-trigger match bits |
| out_valid | output | 1 | Result valid, one cycle after `in_valid` |
| fire | output | 10 | Final per-trigger fire decisions |
| fire_now | output | 1 | Some fired trigger requests a trap before the instruction |
| fire_next | output | 1 | Some fired trigger requests a trap after the instruction |
| any_hit | output | 1 | OR of all fired fetch and memory triggers |
| cfg_err | output | 1 | Forbidden store-store chain is configured |

## Verification
A configuration write and a hit evaluation can land in the same clock edge. The bench provokes this by disabling trigger 1 of chained pair 0 in the same cycle that it presents a hit on both members of that pair. It expects the pair to fire on that evaluation, because the old configuration applies. It then expects the same hit vector, presented on its own one cycle later, to fire nothing.

// File: rtl/trig_chain_resolver.sv
module trig_chain_resolver #(
  parameter int NGRP = 5
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              cfg_fe_we,
  input  logic [1:0]        cfg_fe_idx,
  input  logic [2:0]        cfg_fe_data,
  input  logic              cfg_me_we,
  input  logic [2:0]        cfg_me_idx,
  input  logic [2:0]        cfg_me_data,
  input  logic              in_valid,
  input  logic [2*NGRP-1:0] hit,
  output logic              out_valid,
  output logic [2*NGRP-1:0] fire,
  output logic              fire_now,
  output logic              fire_next,
  output logic              any_hit,
  output logic              cfg_err
);
  localparam int NTRG = 2 * NGRP;
  localparam int STORE_GRP = 1;
  localparam logic [NTRG-1:0] FE_MASK = NTRG'(10'h143);
  localparam logic [NTRG-1:0] ME_MASK = ~FE_MASK;

  logic [NTRG-1:0] en_q, tim_q, fe_sel, me_sel, act, fire_c;
  logic [NGRP-1:0] chain_q;

  always_comb begin
    fe_sel = '0;
    if (cfg_fe_we)
      case (cfg_fe_idx)
        2'd0: fe_sel[0] = 1'b1;
        2'd1: fe_sel[1] = 1'b1;
        2'd2: fe_sel[6] = 1'b1;
        default: fe_sel[8] = 1'b1;
      endcase
  end

  always_comb begin
    me_sel = '0;
    if (cfg_me_we)
      case (cfg_me_idx)
        3'd0: me_sel[2] = 1'b1;
        3'd1: me_sel[3] = 1'b1;
        3'd2: me_sel[4] = 1'b1;
        3'd3: me_sel[5] = 1'b1;
        3'd4: me_sel[7] = 1'b1;
        3'd5: me_sel[9] = 1'b1;
        default: ;
      endcase
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      en_q    <= '0;
      tim_q   <= '0;
      chain_q <= '0;
    end else begin
      for (int i = 0; i < NTRG; i++) begin
        if (fe_sel[i]) begin
          en_q[i]  <= cfg_fe_data[0];
          tim_q[i] <= cfg_fe_data[1];
          if (i % 2 == 0) chain_q[i/2] <= cfg_fe_data[2];
        end else if (me_sel[i]) begin
          en_q[i]  <= cfg_me_data[0];
          tim_q[i] <= cfg_me_data[1];
          if (i % 2 == 0) chain_q[i/2] <= cfg_me_data[2];
        end
      end
    end
  end

  assign act = en_q & hit;

  for (genvar g = 0; g < NGRP; g++) begin : g_pair
    logic ch, both;
    assign ch   = chain_q[g] & (g != STORE_GRP);
    assign both = act[2*g] & act[2*g+1] & (tim_q[2*g] == tim_q[2*g+1]);
    assign fire_c[2*g]   = ch ? both : act[2*g];
    assign fire_c[2*g+1] = ch ? both : act[2*g+1];
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      out_valid <= 1'b0;
      fire      <= '0;
      fire_now  <= 1'b0;
      fire_next <= 1'b0;
      any_hit   <= 1'b0;
    end else begin
      out_valid <= in_valid;
      fire      <= in_valid ? fire_c : '0;
      fire_now  <= in_valid & |(fire_c & ~tim_q);
      fire_next <= in_valid & |(fire_c & tim_q);
      any_hit   <= in_valid & (|(fire_c & FE_MASK) | |(fire_c & ME_MASK));
    end
  end

  assign cfg_err = chain_q[STORE_GRP];

  // R2
  out_valid_chk: assert property (@(posedge clk) disable iff (rst)
    !in_valid |=> (!out_valid && fire == '0 && !any_hit));
  // R4
  disabled_quiet_chk: assert property (@(posedge clk) disable iff (rst)
    out_valid |-> ((fire & ~$past(en_q)) == '0));
  // R5
  chain0_pair_chk: assert property (@(posedge clk) disable iff (rst)
    (out_valid && $past(chain_q[0])) |-> (fire[0] == fire[1]));
  // R8
  flags_need_fire_chk: assert property (@(posedge clk) disable iff (rst)
    (fire == '0) |-> (!fire_now && !fire_next && !any_hit));
  // R8
  now_has_source_chk: assert property (@(posedge clk) disable iff (rst)
    fire_now |-> ((fire & ~$past(tim_q)) != '0));
endmodule

// File: tb/tb_trig_chain_resolver.sv
`timescale 1ns/1ps
module tb_trig_chain_resolver;
  logic clk = 1'b0, rst = 1'b1;
  logic cfg_fe_we = 0, cfg_me_we = 0, in_valid = 0;
  logic [1:0] cfg_fe_idx = 0;
  logic [2:0] cfg_me_idx = 0, cfg_fe_data = 0, cfg_me_data = 0;
  logic [9:0] hit = 0, fire;
  logic out_valid, fire_now, fire_next, any_hit, cfg_err;
  int tests = 0, fails = 0;
  bit done = 0;

  always #4 clk = ~clk;

  trig_chain_resolver dut (
    .clk(clk), .rst(rst),
    .cfg_fe_we(cfg_fe_we), .cfg_fe_idx(cfg_fe_idx), .cfg_fe_data(cfg_fe_data),
    .cfg_me_we(cfg_me_we), .cfg_me_idx(cfg_me_idx), .cfg_me_data(cfg_me_data),
    .in_valid(in_valid), .hit(hit),
    .out_valid(out_valid), .fire(fire), .fire_now(fire_now),
    .fire_next(fire_next), .any_hit(any_hit), .cfg_err(cfg_err));

  // {hit, expected fire, expected fire_now, expected fire_next}
  localparam int NV = 12;
  localparam logic [21:0] VEC [NV] = '{
    {10'h3FF, 10'h1CF, 1'b1, 1'b1},
    {10'h001, 10'h000, 1'b0, 1'b0},
    {10'h003, 10'h003, 1'b1, 1'b0},
    {10'h004, 10'h004, 1'b1, 1'b0},
    {10'h030, 10'h000, 1'b0, 1'b0},
    {10'h0C0, 10'h0C0, 1'b0, 1'b1},
    {10'h040, 10'h000, 1'b0, 1'b0},
    {10'h200, 10'h000, 1'b0, 1'b0},
    {10'h100, 10'h100, 1'b1, 1'b0},
    {10'h300, 10'h100, 1'b1, 1'b0},
    {10'h000, 10'h000, 1'b0, 1'b0},
    {10'h2C8, 10'h0C8, 1'b1, 1'b1}
  };

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    tests++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s: got %0h expected %0h", req, act, exp);
    end
  endtask

  task automatic wr_fe(input logic [1:0] idx, input logic [2:0] d);
    @(negedge clk);
    cfg_fe_we = 1; cfg_fe_idx = idx; cfg_fe_data = d;
    @(negedge clk);
    cfg_fe_we = 0;
  endtask

  task automatic wr_me(input logic [2:0] idx, input logic [2:0] d);
    @(negedge clk);
    cfg_me_we = 1; cfg_me_idx = idx; cfg_me_data = d;
    @(negedge clk);
    cfg_me_we = 0;
  endtask

  task automatic eval(input logic [9:0] h);
    @(negedge clk);
    in_valid = 1; hit = h;
    @(negedge clk);
    in_valid = 0; hit = '0;
  endtask

  initial begin
    repeat (3) @(negedge clk);
    chk("R1 out_valid in reset", {31'd0, out_valid}, 0);
    chk("R1 fire in reset", {22'd0, fire}, 0);
    chk("R1 flags in reset", {28'd0, fire_now, fire_next, any_hit, cfg_err}, 0);
    rst = 0;
    eval(10'h3FF);
    chk("R1 unconfigured fire", {22'd0, fire}, 0);
    chk("R2 out_valid after in_valid", {31'd0, out_valid}, 1);

    wr_fe(2'd0, 3'b101); wr_fe(2'd1, 3'b001);
    wr_me(3'd0, 3'b101); wr_me(3'd1, 3'b001);
    wr_me(3'd2, 3'b101); wr_me(3'd3, 3'b011);
    wr_fe(2'd2, 3'b111); wr_me(3'd4, 3'b011);
    wr_fe(2'd3, 3'b001);
    chk("R7 cfg_err with store chain", {31'd0, cfg_err}, 1);

    for (int i = 0; i < NV; i++) begin
      eval(VEC[i][21:12]);
      // R3 R4 R5 R6 R7 R8 R9 R10 covered by the table
      chk($sformatf("R3/R5/R6 fire vec %0d", i), {22'd0, fire}, {22'd0, VEC[i][11:2]});
      chk($sformatf("R8 fire_now vec %0d", i), {31'd0, fire_now}, {31'd0, VEC[i][1]});
      chk($sformatf("R8 fire_next vec %0d", i), {31'd0, fire_next}, {31'd0, VEC[i][0]});
      chk($sformatf("R9 any_hit vec %0d", i), {31'd0, any_hit}, {31'd0, |VEC[i][11:2]});
    end

    @(negedge clk);
    chk("R2 idle out_valid", {31'd0, out_valid}, 0);
    chk("R2 idle fire", {22'd0, fire}, 0);

    // R11: disable trigger 1 in the same cycle as an evaluation
    @(negedge clk);
    cfg_fe_we = 1; cfg_fe_idx = 2'd1; cfg_fe_data = 3'b000;
    in_valid = 1; hit = 10'h003;
    @(negedge clk);
    cfg_fe_we = 0; in_valid = 0; hit = '0;
    chk("R11 old config used", {22'd0, fire}, 32'h003);
    eval(10'h003);
    chk("R4 disabled partner blocks pair", {22'd0, fire}, 0);

    wr_me(3'd6, 3'b011);
    eval(10'h3FF);
    chk("R10 memory index 6 ignored", {22'd0, fire}, 32'h1CC);

    wr_me(3'd5, 3'b101);
    eval(10'h200);
    chk("R10 odd trigger chain bit ignored", {22'd0, fire}, 32'h200);

    wr_me(3'd0, 3'b001);
    chk("R7 cfg_err cleared", {31'd0, cfg_err}, 0);

    done = 1;
    $display("[TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      tests++; fails++;
      $display("FAIL watchdog: got timeout expected completion");
      $display("[TB] %0d tests run, %0d failed", tests, fails);
      $finish;
    end
  end
endmodule